// File: doc/BRIEF.md
# Unlock Command Sequence Decoder

This block sits between a host's byte-write stream and the page write sequencer of a flash-style storage device. It watches every host write (a 15-bit command address plus one data byte) and recognises the multi-write unlock sequences that guard dangerous operations. Every sequence starts with the same two-write key: AAh to address 5555h, then 55h to address 2AAAh. The third write picks the branch. It can open a protected page load, leave identification mode, or extend into a second key whose final byte selects protection removal, chip erase or identification entry.

The decoder holds a write-protect flag that survives every sequence except an explicit enable or disable. It uses that flag to decide whether each ordinary host write is forwarded to the page write sequencer. Commands appear as single-cycle request pulses. While identification mode is active, the block supplies the maker and part identification bytes for reads at addresses 0 and 1. The storage array, erase timing and pad behaviour live elsewhere.

Top module: `cmd_unlock_dec`

## Requirements
- R1: After reset, prot_on is 1, id_mode is 0, and pass_we and all five command pulses are 0.
- R2: The key is AAh at 5555h followed by 55h at 2AAAh, and all 15 address bits are compared. A wrong address or data byte at any step aborts the sequence.
- R3: A third write of A0h at 5555h after the key pulses prot_set, leaves prot_on at 1 and opens a load window. Writes inside the window are forwarded even when protection is on.
- R4: The load window stays open while consecutive writes are separated by at most LOAD_IDLE-1 idle cycles. It closes after LOAD_IDLE consecutive cycles with no write.
- R5: While prot_on is 1, an ordinary write outside a load window is not forwarded.
- R6: While prot_on is 0, an ordinary write is forwarded: pass_we is 1 for one cycle, with pass_addr and pass_data equal to the write's address and data.
- R7: The six writes AAh@5555h, 55h@2AAAh, 80h@5555h, AAh@5555h, 55h@2AAAh, 20h@5555h pulse prot_clr and set prot_on to 0. prot_on changes only on prot_set or prot_clr.
- R8: The same six-write form ending in 10h pulses erase_req.
- R9: The six-write form ending in 60h pulses id_enter and sets id_mode. While id_mode is 1, id_rdata is DAh for address 0, C1h for address 1 and 00h for any other address. While id_mode is 0, id_rdata is 00h.
- R10: The key followed by F0h at 5555h pulses id_exit and clears id_mode.
- R11: A write that aborts a sequence is discarded: it is not forwarded, raises no pulse and changes no flag. The decoder is then idle, so the next ordinary write behaves as in R5 or R6.
- R12: Each command pulse lasts exactly one cycle, and at most one of the five pulses is high in any cycle.
- R13: Outside a load window, a write of AAh at 5555h is taken as the start of a key and is never forwarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_stb | input | 1 | Host write strobe, one cycle per byte write |
| bus_addr | input | 15 | Host address, used for writes and identification reads |
| bus_wdata | input | 8 | Host write data |
| pass_we | output | 1 | Forwarded-write strobe to the page write sequencer |
| pass_addr | output | 15 | Address of the forwarded write |
| pass_data | output | 8 | Data of the forwarded write |
| erase_req | output | 1 | Chip-erase request pulse |
| prot_set | output | 1 | Protection-enable pulse |
| prot_clr | output | 1 | Protection-disable pulse |
| id_enter | output | 1 | Identification-entry pulse |
| id_exit | output | 1 | Identification-exit pulse |
| prot_on | output | 1 | Write-protect flag |
| id_mode | output | 1 | Identification mode active |
| id_rdata | output | 8 | Identification byte for the current address |

## Verification
Every write-driven result is registered. pass_we, pass_addr, pass_data, the five pulses, prot_on and id_mode therefore change on the same rising edge that samples the strobe. The bench drives a write on a falling edge, drops it on the next falling edge and compares the outputs at that point, exactly one cycle after the stimulus. id_rdata is combinational from id_mode and bus_addr, so it is compared within the cycle after the address is set. The load-window limit is probed with gaps of exactly LOAD_IDLE-1 and LOAD_IDLE idle cycles. Pulse width is confirmed by sampling again one cycle after a command.

// File: rtl/cmd_unlock_pkg.sv
package cmd_unlock_pkg;

  localparam int CMD_AW = 15;
  localparam int CMD_DW = 8;
  localparam int ID_N   = 2;

  localparam logic [CMD_AW-1:0] KEY_ADDR_A = 15'h5555;
  localparam logic [CMD_AW-1:0] KEY_ADDR_B = 15'h2AAA;

  localparam logic [CMD_DW-1:0] KEY_BYTE_1   = 8'hAA;
  localparam logic [CMD_DW-1:0] KEY_BYTE_2   = 8'h55;
  localparam logic [CMD_DW-1:0] OP_PROT_LOAD = 8'hA0;
  localparam logic [CMD_DW-1:0] OP_EXTEND    = 8'h80;
  localparam logic [CMD_DW-1:0] OP_ID_LEAVE  = 8'hF0;
  localparam logic [CMD_DW-1:0] OP_UNPROT    = 8'h20;
  localparam logic [CMD_DW-1:0] OP_ERASE     = 8'h10;
  localparam logic [CMD_DW-1:0] OP_ID_ENTER  = 8'h60;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_KEY1  = 3'd1,
    ST_KEY2  = 3'd2,
    ST_EXT0  = 3'd3,
    ST_EXT1  = 3'd4,
    ST_EXT2  = 3'd5,
    ST_LOAD  = 3'd6
  } seq_st_e;

  typedef struct packed {
    logic key1;
    logic key2;
    logic op_load;
    logic op_ext;
    logic op_leave;
    logic op_unprot;
    logic op_erase;
    logic op_idin;
  } step_hit_t;

  typedef struct packed {
    logic erase;
    logic set;
    logic clr;
    logic idin;
    logic idout;
  } cmd_pulse_t;

  function automatic logic [CMD_DW-1:0] id_code(input int idx);
    case (idx)
      0:       id_code = 8'hDA;
      1:       id_code = 8'hC1;
      default: id_code = '0;
    endcase
  endfunction

endpackage

// File: rtl/cud_step_match.sv
module cud_step_match
  import cmd_unlock_pkg::*;
(
  input  logic [CMD_AW-1:0] addr,
  input  logic [CMD_DW-1:0] data,
  output step_hit_t         hit
);

  logic at_a;
  logic at_b;

  always_comb begin
    at_a = (addr == KEY_ADDR_A);
    at_b = (addr == KEY_ADDR_B);

    hit.key1      = at_a && (data == KEY_BYTE_1);
    hit.key2      = at_b && (data == KEY_BYTE_2);
    hit.op_load   = at_a && (data == OP_PROT_LOAD);
    hit.op_ext    = at_a && (data == OP_EXTEND);
    hit.op_leave  = at_a && (data == OP_ID_LEAVE);
    hit.op_unprot = at_a && (data == OP_UNPROT);
    hit.op_erase  = at_a && (data == OP_ERASE);
    hit.op_idin   = at_a && (data == OP_ID_ENTER);
  end

endmodule

// File: rtl/cud_load_timer.sv
module cud_load_timer #(
  parameter int LOAD_IDLE = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic in_load,
  input  logic stb,
  output logic expire
);

  localparam int CW = $clog2(LOAD_IDLE + 1);
  localparam logic [CW-1:0] LAST = CW'(LOAD_IDLE - 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          cnt_en;

  always_comb begin
    expire = in_load && !stb && (cnt_q == LAST);
    cnt_en = in_load || (cnt_q != '0);
    if (stb || !in_load) cnt_d = '0;
    else                 cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

endmodule

// File: rtl/cud_seq_fsm.sv
module cud_seq_fsm
  import cmd_unlock_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       stb,
  input  step_hit_t  hit,
  input  logic       win_expire,
  output logic       in_load,
  output logic       pass_now,
  output cmd_pulse_t pulse_q,
  output logic       prot_q,
  output logic       id_q
);

  seq_st_e    st_q, st_d;
  cmd_pulse_t pulse_d;
  logic       prot_d;
  logic       id_d;

  assign in_load = (st_q == ST_LOAD);

  always_comb begin
    st_d     = st_q;
    pulse_d  = '0;
    prot_d   = prot_q;
    id_d     = id_q;
    pass_now = 1'b0;
    if (stb) begin
      case (st_q)
        ST_IDLE: begin
          if (hit.key1) st_d = ST_KEY1;
          else          pass_now = !prot_q;
        end
        ST_KEY1: st_d = hit.key2 ? ST_KEY2 : ST_IDLE;
        ST_KEY2: begin
          if (hit.op_load) begin
            st_d        = ST_LOAD;
            prot_d      = 1'b1;
            pulse_d.set = 1'b1;
          end else if (hit.op_ext) begin
            st_d = ST_EXT0;
          end else if (hit.op_leave) begin
            st_d          = ST_IDLE;
            id_d          = 1'b0;
            pulse_d.idout = 1'b1;
          end else begin
            st_d = ST_IDLE;
          end
        end
        ST_EXT0: st_d = hit.key1 ? ST_EXT1 : ST_IDLE;
        ST_EXT1: st_d = hit.key2 ? ST_EXT2 : ST_IDLE;
        ST_EXT2: begin
          st_d = ST_IDLE;
          if (hit.op_unprot) begin
            prot_d      = 1'b0;
            pulse_d.clr = 1'b1;
          end else if (hit.op_erase) begin
            pulse_d.erase = 1'b1;
          end else if (hit.op_idin) begin
            id_d         = 1'b1;
            pulse_d.idin = 1'b1;
          end
        end
        ST_LOAD: pass_now = 1'b1;
        default: st_d = ST_IDLE;
      endcase
    end else if (in_load && win_expire) begin
      st_d = ST_IDLE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      pulse_q <= '0;
      prot_q  <= 1'b1;
      id_q    <= 1'b0;
    end else begin
      st_q    <= st_d;
      pulse_q <= pulse_d;
      prot_q  <= prot_d;
      id_q    <= id_d;
    end
  end

endmodule

// File: rtl/cud_id_rom.sv
module cud_id_rom
  import cmd_unlock_pkg::*;
(
  input  logic              id_on,
  input  logic [CMD_AW-1:0] addr,
  output logic [CMD_DW-1:0] rdata
);

  logic [ID_N-1:0][CMD_DW-1:0] term;

  for (genvar i = 0; i < ID_N; i++) begin : g_id
    assign term[i] = (addr == CMD_AW'(i)) ? id_code(i) : '0;
  end

  always_comb begin
    rdata = '0;
    for (int i = 0; i < ID_N; i++) rdata = rdata | term[i];
    if (!id_on) rdata = '0;
  end

endmodule

// File: rtl/cmd_unlock_dec.sv
module cmd_unlock_dec
  import cmd_unlock_pkg::*;
#(
  parameter int LOAD_IDLE = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_stb,
  input  logic [CMD_AW-1:0] bus_addr,
  input  logic [CMD_DW-1:0] bus_wdata,
  output logic              pass_we,
  output logic [CMD_AW-1:0] pass_addr,
  output logic [CMD_DW-1:0] pass_data,
  output logic              erase_req,
  output logic              prot_set,
  output logic              prot_clr,
  output logic              id_enter,
  output logic              id_exit,
  output logic              prot_on,
  output logic              id_mode,
  output logic [CMD_DW-1:0] id_rdata
);

  logic       rst_meta, rst_sync;
  step_hit_t  hit;
  logic       in_load;
  logic       win_expire;
  logic       pass_now;
  cmd_pulse_t pulse;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_sync <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_sync <= rst_meta;
    end
  end

  cud_step_match u_match (
    .addr (bus_addr),
    .data (bus_wdata),
    .hit  (hit)
  );

  cud_load_timer #(.LOAD_IDLE(LOAD_IDLE)) u_timer (
    .clk     (clk),
    .rst_n   (rst_sync),
    .in_load (in_load),
    .stb     (wr_stb),
    .expire  (win_expire)
  );

  cud_seq_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_sync),
    .stb        (wr_stb),
    .hit        (hit),
    .win_expire (win_expire),
    .in_load    (in_load),
    .pass_now   (pass_now),
    .pulse_q    (pulse),
    .prot_q     (prot_on),
    .id_q       (id_mode)
  );

  cud_id_rom u_id (
    .id_on (id_mode),
    .addr  (bus_addr),
    .rdata (id_rdata)
  );

  always_ff @(posedge clk or negedge rst_sync) begin
    if (!rst_sync) pass_we <= 1'b0;
    else           pass_we <= pass_now;
  end

  always_ff @(posedge clk) begin
    if (pass_now) begin
      pass_addr <= bus_addr;
      pass_data <= bus_wdata;
    end
  end

  assign erase_req = pulse.erase;
  assign prot_set  = pulse.set;
  assign prot_clr  = pulse.clr;
  assign id_enter  = pulse.idin;
  assign id_exit   = pulse.idout;

endmodule

// File: rtl/cmd_unlock_dec_chk.sv
module cmd_unlock_dec_chk
  import cmd_unlock_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              wr_stb,
  input logic [CMD_AW-1:0] bus_addr,
  input logic [CMD_DW-1:0] bus_wdata,
  input logic              pass_we,
  input logic [CMD_AW-1:0] pass_addr,
  input logic [CMD_DW-1:0] pass_data,
  input logic              erase_req,
  input logic              prot_set,
  input logic              prot_clr,
  input logic              id_enter,
  input logic              id_exit,
  input logic              prot_on,
  input logic              id_mode,
  input logic [CMD_DW-1:0] id_rdata
);

  logic [4:0] pulses;
  assign pulses = {erase_req, prot_set, prot_clr, id_enter, id_exit};

  p_pulse_excl_r12: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(pulses));

  p_erase_single_r12: assert property (@(posedge clk) disable iff (!rst_n)
    erase_req |=> !erase_req);

  p_set_level_r3: assert property (@(posedge clk) disable iff (!rst_n)
    prot_set |-> prot_on);

  p_prot_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(prot_on) |-> (prot_set || prot_clr));

  p_clr_level_r7: assert property (@(posedge clk) disable iff (!rst_n)
    prot_clr |-> !prot_on);

  p_erase_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
    erase_req |-> ($past(wr_stb) && $past(bus_wdata) == OP_ERASE));

  p_id_enter_r9: assert property (@(posedge clk) disable iff (!rst_n)
    id_enter |-> id_mode);

  p_id_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !id_mode |-> (id_rdata == '0));

  p_id_exit_r10: assert property (@(posedge clk) disable iff (!rst_n)
    id_exit |-> !id_mode);

  p_pass_copy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    pass_we |-> ($past(wr_stb) && pass_addr == $past(bus_addr)
                 && pass_data == $past(bus_wdata)));

endmodule

bind cmd_unlock_dec cmd_unlock_dec_chk u_chk (.*);

// File: tb/cmd_unlock_dec_test.sv
module cmd_unlock_dec_test;

  localparam int LOAD_IDLE = 8;
  localparam int NVEC      = 42;

  typedef struct packed {
    logic [7:0]  gap;
    logic [14:0] addr;
    logic [7:0]  data;
    logic        pass;
    logic [4:0]  pulse;  // {erase, set, clr, idin, idout}
    logic        prot;
    logic        id;
    logic [3:0]  req;
  } vec_t;

  localparam vec_t VEC [NVEC] = '{
    '{8'd0, 15'h1234, 8'h5A, 1'b0, 5'b00000, 1'b1, 1'b0, 4'd5},  // R5 rejected while protected
    '{8'd0, 15'h5555, 8'hAA, 1'b0, 5'b00000, 1'b1, 1'b0, 4'd13}, // R13 key start kept
    '{8'd0, 15'h2AAA, 8'h55, 1'b0, 5'b00000, 1'b1, 1'b0, 4'd2},  // R2
    '{8'd0, 15'h5555, 8'hA0, 1'b0, 5'b01000, 1'b1, 1'b0, 4'd3},  // R3 enable + window
    '{8'd0, 15'h0100, 8'h11, 1'b1, 5'b00000, 1'b1, 1'b0, 4'd3},  // R3 load passes
    '{8'd3, 15'h0101, 8'h22, 1'b1, 5'b00000, 1'b1, 1'b0, 4'd4},  // R4 short gap
    '{8'd8, 15'h0102, 8'h33, 1'b0, 5'b00000, 1'b1, 1'b0, 4'd4},  // R4 window closed
    '{8'd0, 15'h5555, 8'hAA, 1'b0, 5'b00000, 1'b1, 1'b0, 4'd7},  // R7
    '{8'd0, 15'h2AAA, 8'h55, 1'b0, 5'b00000, 1'b1, 1'b0, 4'd7},
    '{8'd0, 15'h5555, 8'h80, 1'b0, 5'b00000, 1'b1, 1'b0, 4'd7},
    '{8'd0, 15'h5555, 8'hAA, 1'b0, 5'b00000, 1'b1, 1'b0, 4'd7},
    '{8'd0, 15'h2AAA, 8'h55, 1'b0, 5'b00000, 1'b1, 1'b0, 4'd7},
    '{8'd0, 15'h5555, 8'h20, 1'b0, 5'b00100, 1'b0, 1'b0, 4'd7},  // R7 disable
    '{8'd0, 15'h0200, 8'h44, 1'b1, 5'b00000, 1'b0, 1'b0, 4'd6},  // R6 pass through
    '{8'd0, 15'h5555, 8'hAA, 1'b0, 5'b00000, 1'b0, 1'b0, 4'd13}, // R13
    '{8'd0, 15'h1234, 8'h77, 1'b0, 5'b00000, 1'b0, 1'b0, 4'd11}, // R11 abort discarded
    '{8'd0, 15'h0201, 8'h55, 1'b1, 5'b00000, 1'b0, 1'b0, 4'd11}, // R11 idle again
    '{8'd0, 15'h5555, 8'hAA, 1'b0, 5'b00000, 1'b0, 1'b0, 4'd2},
    '{8'd0, 15'h2AAA, 8'h55, 1'b0, 5'b00000, 1'b0, 1'b0, 4'd2},
    '{8'd0, 15'h5555, 8'h99, 1'b0, 5'b00000, 1'b0, 1'b0, 4'd2},  // R2 bad third byte
    '{8'd0, 15'h0202, 8'h66, 1'b1, 5'b00000, 1'b0, 1'b0, 4'd11}, // R11
    '{8'd0, 15'h5555, 8'hAA, 1'b0, 5'b00000, 1'b0, 1'b0, 4'd2},
    '{8'd0, 15'h2AAB, 8'h55, 1'b0, 5'b00000, 1'b0, 1'b0, 4'd2},  // R2 address bit mismatch
    '{8'd0, 15'h5555, 8'hAA, 1'b0, 5'b00000, 1'b0, 1'b0, 4'd8},  // R8
    '{8'd0, 15'h2AAA, 8'h55, 1'b0, 5'b00000, 1'b0, 1'b0, 4'd8},
    '{8'd0, 15'h5555, 8'h80, 1'b0, 5'b00000, 1'b0, 1'b0, 4'd8},
    '{8'd0, 15'h5555, 8'hAA, 1'b0, 5'b00000, 1'b0, 1'b0, 4'd8},
    '{8'd0, 15'h2AAA, 8'h55, 1'b0, 5'b00000, 1'b0, 1'b0, 4'd8},
    '{8'd0, 15'h5555, 8'h10, 1'b0, 5'b10000, 1'b0, 1'b0, 4'd8},  // R8 erase
    '{8'd0, 15'h5555, 8'hAA, 1'b0, 5'b00000, 1'b0, 1'b0, 4'd9},  // R9
    '{8'd0, 15'h2AAA, 8'h55, 1'b0, 5'b00000, 1'b0, 1'b0, 4'd9},
    '{8'd0, 15'h5555, 8'h80, 1'b0, 5'b00000, 1'b0, 1'b0, 4'd9},
    '{8'd0, 15'h5555, 8'hAA, 1'b0, 5'b00000, 1'b0, 1'b0, 4'd9},
    '{8'd0, 15'h2AAA, 8'h55, 1'b0, 5'b00000, 1'b0, 1'b0, 4'd9},
    '{8'd0, 15'h5555, 8'h60, 1'b0, 5'b00010, 1'b0, 1'b1, 4'd9},  // R9 id entry
    '{8'd0, 15'h5555, 8'hAA, 1'b0, 5'b00000, 1'b0, 1'b1, 4'd10}, // R10
    '{8'd0, 15'h2AAA, 8'h55, 1'b0, 5'b00000, 1'b0, 1'b1, 4'd10},
    '{8'd0, 15'h5555, 8'hF0, 1'b0, 5'b00001, 1'b0, 1'b0, 4'd10}, // R10 id exit
    '{8'd0, 15'h5555, 8'hAA, 1'b0, 5'b00000, 1'b0, 1'b0, 4'd3},
    '{8'd0, 15'h2AAA, 8'h55, 1'b0, 5'b00000, 1'b0, 1'b0, 4'd3},
    '{8'd0, 15'h5555, 8'hA0, 1'b0, 5'b01000, 1'b1, 1'b0, 4'd3},  // R3 re-enable
    '{8'd0, 15'h0300, 8'h66, 1'b1, 5'b00000, 1'b1, 1'b0, 4'd3}
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_stb;
  logic [14:0] bus_addr;
  logic [7:0]  bus_wdata;
  logic        pass_we;
  logic [14:0] pass_addr;
  logic [7:0]  pass_data;
  logic        erase_req, prot_set, prot_clr, id_enter, id_exit;
  logic        prot_on, id_mode;
  logic [7:0]  id_rdata;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  cmd_unlock_dec #(.LOAD_IDLE(LOAD_IDLE)) uut (
    .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .pass_we(pass_we), .pass_addr(pass_addr),
    .pass_data(pass_data), .erase_req(erase_req), .prot_set(prot_set),
    .prot_clr(prot_clr), .id_enter(id_enter), .id_exit(id_exit),
    .prot_on(prot_on), .id_mode(id_mode), .id_rdata(id_rdata)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, got, exp);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  // caller is at a falling edge; outputs of the write are checked on return
  task automatic do_write(input logic [14:0] a, input logic [7:0] d, input int gap);
    repeat (gap) @(negedge clk);
    wr_stb = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    wr_stb = 1'b0;
  endtask

  task automatic seq6(input logic [7:0] op);
    do_write(15'h5555, 8'hAA, 0);
    do_write(15'h2AAA, 8'h55, 0);
    do_write(15'h5555, 8'h80, 0);
    do_write(15'h5555, 8'hAA, 0);
    do_write(15'h2AAA, 8'h55, 0);
    do_write(15'h5555, op, 0);
  endtask

  task automatic seq3(input logic [7:0] op);
    do_write(15'h5555, 8'hAA, 0);
    do_write(15'h2AAA, 8'h55, 0);
    do_write(15'h5555, op, 0);
  endtask

  task automatic chk_idle_outputs(input string req);
    chk(req, "pass_we", pass_we, 0);
    chk(req, "pulses", {erase_req, prot_set, prot_clr, id_enter, id_exit}, 0);
    chk(req, "prot_on", prot_on, 1);
    chk(req, "id_mode", id_mode, 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    rst_n = 1'b0; wr_stb = 1'b0; bus_addr = '0; bus_wdata = '0;
    repeat (3) @(negedge clk);
    chk_idle_outputs("R1");
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk_idle_outputs("R1");

    for (int i = 0; i < NVEC; i++) begin
      string rq;
      rq = $sformatf("R%0d", VEC[i].req);
      do_write(VEC[i].addr, VEC[i].data, int'(VEC[i].gap));
      chk(rq, $sformatf("v%0d pass_we", i), pass_we, VEC[i].pass);
      if (VEC[i].pass) begin
        chk(rq, $sformatf("v%0d pass_addr", i), pass_addr, VEC[i].addr);
        chk(rq, $sformatf("v%0d pass_data", i), pass_data, VEC[i].data);
      end
      chk(rq, $sformatf("v%0d pulses", i),
          {erase_req, prot_set, prot_clr, id_enter, id_exit}, VEC[i].pulse);
      chk(rq, $sformatf("v%0d prot_on", i), prot_on, VEC[i].prot);
      chk(rq, $sformatf("v%0d id_mode", i), id_mode, VEC[i].id);
    end

    // R4 window edge: LOAD_IDLE-1 idle cycles keep it open, LOAD_IDLE close it
    do_write(15'h0301, 8'h77, LOAD_IDLE - 1);
    chk("R4", "gap LOAD_IDLE-1 pass_we", pass_we, 1);
    do_write(15'h0302, 8'h78, LOAD_IDLE);
    chk("R4", "gap LOAD_IDLE pass_we", pass_we, 0);

    // R12 pulse width
    seq6(8'h10);
    chk("R12", "erase_req first cycle", erase_req, 1);
    @(negedge clk);
    chk("R12", "erase_req next cycle", erase_req, 0);

    // R9 identification reads
    seq6(8'h60);
    chk("R9", "id_mode", id_mode, 1);
    bus_addr = 15'h0000; #1;
    chk("R9", "id_rdata @0", id_rdata, 8'hDA);
    bus_addr = 15'h0001; #1;
    chk("R9", "id_rdata @1", id_rdata, 8'hC1);
    bus_addr = 15'h0002; #1;
    chk("R9", "id_rdata @2", id_rdata, 8'h00);
    @(negedge clk);
    seq3(8'hF0);
    chk("R10", "id_mode after exit", id_mode, 0);
    bus_addr = 15'h0000; #1;
    chk("R9", "id_rdata @0 outside id mode", id_rdata, 8'h00);
    @(negedge clk);

    // R1 mid-run reset restores protection
    seq6(8'h20);
    chk("R7", "prot_on before reset", prot_on, 0);
    rst_n = 1'b0; #1;
    chk_idle_outputs("R1");
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    do_write(15'h0400, 8'h12, 0);
    chk("R5", "after reset pass_we", pass_we, 0);

    summary();
    $finish;
  end

endmodule